// File: doc/BRIEF.md
# DMA Page Address Extender

This block widens the 16-bit transfer offsets produced by an ISA-style DMA controller into a 32-bit system memory address. Each of four DMA channels owns a 16-bit page value. Software loads the page in two halves through two byte-wide register windows. The low-page window is readable and contains scratch bytes. The high-page window is write-only. Each window is 16 bytes long and is divided into two banks of eight slots. Only bank 0 takes part in address formation.

The block watches the four active-low acknowledge lines of the controller to learn which channel owns the bus. Each transfer offset enters on a valid/ready stream. It leaves one cycle later as a full address built from that channel's bank-0 page. The output stage is a single register. The input is ready when that register is empty or is being drained in the same cycle. The output holds its valid and address steady for as long as the consumer withholds ready. The block also turns the controller's hold request into a halt for the primary processor and a hold acknowledge back to the controller.

Top module: `dma_page_ext`

## Requirements
- R1: After reset, every page byte, every scratch byte and the current channel are zero. `addr_valid`, `cpu_halt` and `hold_ack` are low. All 16 window offsets read 0x00.
- R2: Window offset bits [2:0] select a channel only at four slot values: slot 1 selects channel 2, slot 2 selects channel 3, slot 3 selects channel 1 and slot 7 selects channel 0. Offset bit 3 selects bank 0 or bank 1. All other slots are scratch.
- R3: A `lo_wr` to a channel slot replaces page bits [7:0] of that bank and channel and keeps bits [15:8].
- R4: An `hi_wr` to a channel slot replaces page bits [15:8] and keeps bits [7:0]. An `hi_wr` to a scratch slot changes nothing that can be observed.
- R5: `win_rdata` follows `win_addr` combinationally. At a channel slot it shows the low page byte of that bank and channel. At a scratch slot it shows the byte last written there with `lo_wr`. Each of the eight scratch offsets is distinct.
- R6: Bank 1 pages are stored and read back, but they never alter a formed address.
- R7: The current channel is loaded when a `dack_n` bit changes from 1 to 0. If several bits fall in the same cycle, the lowest index wins. Otherwise the current channel holds, including when a line stays low or rises.
- R8: An accepted offset yields `addr_data = ((page << 16) & 0x7FFF0000) + offset`. The page and channel are those in effect in the acceptance cycle. Bit 31 is always 0.
- R9: `ofs_ready` is high when the output register is empty or `addr_ready` is high. The address appears one cycle after acceptance. While `addr_valid` is high and `addr_ready` is low, `addr_valid` and `addr_data` stay stable.
- R10: `cpu_halt` and `hold_ack` both equal `hold_req` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_addr | input | 4 | Offset within the register windows |
| lo_wr | input | 1 | Write strobe, low-page window |
| hi_wr | input | 1 | Write strobe, high-page window |
| win_wdata | input | 8 | Write data for either window |
| win_rdata | output | 8 | Low-page window read data |
| dack_n | input | 4 | Active-low channel acknowledges |
| hold_req | input | 1 | Hold request from the DMA controller |
| cpu_halt | output | 1 | Halt to the primary processor |
| hold_ack | output | 1 | Hold acknowledge to the DMA controller |
| ofs_valid | input | 1 | Transfer offset valid |
| ofs_ready | output | 1 | Transfer offset accepted when high with valid |
| ofs_data | input | 16 | Transfer offset from the DMA controller |
| addr_valid | output | 1 | System address valid |
| addr_ready | input | 1 | Consumer ready for the system address |
| addr_data | output | 32 | Formed system address |

## Verification
A wrong slot-to-channel decode or a wrong bank choice shows as a wrong `win_rdata` in the same cycle that the offset is presented. It also shows on the next formed address that uses the affected channel. A current-channel register that fails to latch on a falling acknowledge, or latches on the wrong event, goes unseen until the next offset is accepted. One cycle after that acceptance the address carries another channel's page. A broken output register is caught by holding `addr_ready` low and seeing valid drop or the address move while stalled.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int CH_N   = 4;
  localparam int CH_W   = 2;
  localparam int SLOT_W = 3;
  localparam int WIN_AW = 4;
  localparam int WIN_SZ = 1 << WIN_AW;
  localparam int BANKS  = 2;

  // slots (offset mod 8) that carry a channel page rather than a scratch byte
  localparam logic [7:0] MAPPED_SLOTS = 8'b1000_1110;

  typedef struct packed {
    logic            hit;
    logic [CH_W-1:0] ch;
  } slot_map_t;

  // non-linear slot to channel decode
  function automatic slot_map_t map_slot(input logic [SLOT_W-1:0] s);
    slot_map_t m;
    m = '0;
    case (s)
      3'd1: m = '{hit: 1'b1, ch: 2'd2};
      3'd2: m = '{hit: 1'b1, ch: 2'd3};
      3'd3: m = '{hit: 1'b1, ch: 2'd1};
      3'd7: m = '{hit: 1'b1, ch: 2'd0};
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dpx_page_regs.sv
module dpx_page_regs
  import dpx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PAGE_W = 2 * DATA_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WIN_AW-1:0]            win_addr,
  input  logic                         lo_wr,
  input  logic                         hi_wr,
  input  logic [DATA_W-1:0]            win_wdata,
  output logic [DATA_W-1:0]            win_rdata,
  output logic [CH_N-1:0][PAGE_W-1:0]  bank0_pages
);
  slot_map_t           sel;
  logic                bank;
  logic [PAGE_W-1:0]   page_q [BANKS][CH_N];
  logic [WIN_SZ-1:0][DATA_W-1:0] scr;

  assign sel  = map_slot(win_addr[SLOT_W-1:0]);
  assign bank = win_addr[WIN_AW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int c = 0; c < CH_N; c++)
          page_q[b][c] <= '0;
    end else begin
      if (lo_wr && sel.hit) page_q[bank][sel.ch][DATA_W-1:0]      <= win_wdata;
      if (hi_wr && sel.hit) page_q[bank][sel.ch][PAGE_W-1:DATA_W] <= win_wdata;
    end
  end

  // scratch bytes exist only at slots that carry no page
  for (genvar g = 0; g < WIN_SZ; g++) begin : g_scr
    if (MAPPED_SLOTS[g % 8]) begin : g_none
      assign scr[g] = '0;
    end else begin : g_byte
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (lo_wr && (win_addr == WIN_AW'(g))) q <= win_wdata;
      end
      assign scr[g] = q;
    end
  end

  always_comb begin
    if (sel.hit) win_rdata = page_q[bank][sel.ch][DATA_W-1:0];
    else         win_rdata = scr[win_addr];
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_b0
    assign bank0_pages[c] = page_q[0][c];
  end
endmodule

// File: rtl/dpx_chan_track.sv
module dpx_chan_track
  import dpx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_N-1:0] dack_n,
  output logic [CH_W-1:0] cur_ch
);
  logic [CH_N-1:0] dack_prev;
  logic [CH_N-1:0] fell;
  logic [CH_W-1:0] pick;

  assign fell = dack_prev & ~dack_n;

  always_comb begin
    pick = '0;
    for (int i = CH_N - 1; i >= 0; i--)
      if (fell[i]) pick = CH_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dack_prev <= '1;
      cur_ch    <= '0;
    end else begin
      dack_prev <= dack_n;
      if (|fell) cur_ch <= pick;
    end
  end
endmodule

// File: rtl/dpx_addr_stage.sv
module dpx_addr_stage
  import dpx_pkg::*;
#(
  parameter int PAGE_W = 16,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 32,
  parameter int KEEP_W = 31
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CH_N-1:0][PAGE_W-1:0] pages,
  input  logic [CH_W-1:0]             cur_ch,
  input  logic                        ofs_valid,
  output logic                        ofs_ready,
  input  logic [OFS_W-1:0]            ofs_data,
  output logic                        addr_valid,
  input  logic                        addr_ready,
  output logic [ADDR_W-1:0]           addr_data
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = (ADDR_W'(1) << KEEP_W) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_MASK  = (ADDR_W'(1) << OFS_W) - ADDR_W'(1);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] formed;
  logic              take;

  assign base      = (ADDR_W'(pages[cur_ch]) << OFS_W) & KEEP_MASK & ~OFS_MASK;
  assign formed    = base + ADDR_W'(ofs_data);
  assign ofs_ready = !addr_valid || addr_ready;
  assign take      = ofs_valid && ofs_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_data  <= '0;
    end else begin
      if (take) begin
        addr_valid <= 1'b1;
        addr_data  <= formed;
      end else if (addr_ready) begin
        addr_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_page_ext.sv
module dma_page_ext
  import dpx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 32,
  parameter int KEEP_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] win_wdata,
  output logic [DATA_W-1:0] win_rdata,
  input  logic [CH_N-1:0]   dack_n,
  input  logic              hold_req,
  output logic              cpu_halt,
  output logic              hold_ack,
  input  logic              ofs_valid,
  output logic              ofs_ready,
  input  logic [OFS_W-1:0]  ofs_data,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr_data
);
  localparam int PAGE_W = 2 * DATA_W;

  logic [CH_N-1:0][PAGE_W-1:0] bank0_pages;
  logic [CH_W-1:0]             cur_ch;
  logic                        hold_q;

  dpx_page_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_addr   (win_addr),
    .lo_wr      (lo_wr),
    .hi_wr      (hi_wr),
    .win_wdata  (win_wdata),
    .win_rdata  (win_rdata),
    .bank0_pages(bank0_pages)
  );

  dpx_chan_track u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .dack_n(dack_n),
    .cur_ch(cur_ch)
  );

  dpx_addr_stage #(
    .PAGE_W(PAGE_W),
    .OFS_W (OFS_W),
    .ADDR_W(ADDR_W),
    .KEEP_W(KEEP_W)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .pages     (bank0_pages),
    .cur_ch    (cur_ch),
    .ofs_valid (ofs_valid),
    .ofs_ready (ofs_ready),
    .ofs_data  (ofs_data),
    .addr_valid(addr_valid),
    .addr_ready(addr_ready),
    .addr_data (addr_data)
  );

  // one flop drives both halt and acknowledge so they never disagree
  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_req;
  end

  assign cpu_halt = hold_q;
  assign hold_ack = hold_q;
endmodule

// File: rtl/dma_page_ext_chk.sv
module dma_page_ext_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 32,
  parameter int KEEP_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        win_addr,
  input logic              lo_wr,
  input logic [DATA_W-1:0] win_rdata,
  input logic              hold_req,
  input logic              cpu_halt,
  input logic              hold_ack,
  input logic              ofs_valid,
  input logic              ofs_ready,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr_data
);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_data)));

  a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && ofs_ready) |=> addr_valid);

  a_r10_hold_on: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |=> (cpu_halt && hold_ack));

  a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_req |=> (!cpu_halt && !hold_ack));

  a_r5_rdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(lo_wr) && $stable(win_addr)) |-> $stable(win_rdata));

  if (ADDR_W > KEEP_W) begin : g_rng
    a_r8_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> (addr_data[ADDR_W-1:KEEP_W] == '0));
  end
endmodule

bind dma_page_ext dma_page_ext_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .KEEP_W(KEEP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_addr  (win_addr),
  .lo_wr     (lo_wr),
  .win_rdata (win_rdata),
  .hold_req  (hold_req),
  .cpu_halt  (cpu_halt),
  .hold_ack  (hold_ack),
  .ofs_valid (ofs_valid),
  .ofs_ready (ofs_ready),
  .addr_valid(addr_valid),
  .addr_ready(addr_ready),
  .addr_data (addr_data)
);

// File: tb/tb_dma_page_ext.sv
`timescale 1ns/1ps
module tb_dma_page_ext;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  win_addr = '0;
  logic        lo_wr = 1'b0, hi_wr = 1'b0;
  logic [7:0]  win_wdata = '0;
  logic [7:0]  win_rdata;
  logic [3:0]  dack_n = 4'hF;
  logic        hold_req = 1'b0;
  logic        cpu_halt, hold_ack;
  logic        ofs_valid = 1'b0, ofs_ready;
  logic [15:0] ofs_data = '0;
  logic        addr_valid, addr_ready = 1'b1;
  logic [31:0] addr_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_page_ext dut (.*);

  // {channel[1:0], page[15:0], offset[15:0], expected address[31:0]}
  localparam logic [65:0] VEC [4] = '{
    {2'd0, 16'h1234, 16'h5678, 32'h1234_5678},
    {2'd1, 16'hFFFF, 16'hFFFF, 32'h7FFF_FFFF},
    {2'd2, 16'h8001, 16'h0000, 32'h0001_0000},
    {2'd3, 16'h00AB, 16'h00CD, 32'h00AB_00CD}
  };

  function automatic logic [3:0] slot_of(input logic [1:0] ch);
    case (ch)
      2'd0: return 4'd7;
      2'd1: return 4'd3;
      2'd2: return 4'd1;
      default: return 4'd2;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit hi, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    win_addr = a; win_wdata = d; lo_wr = !hi; hi_wr = hi;
    @(negedge clk);
    lo_wr = 1'b0; hi_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    win_addr = a;
    #1 check(win_rdata == exp, req, 32'(win_rdata), 32'(exp));
  endtask

  task automatic pulse(input logic [3:0] mask);
    @(negedge clk) dack_n = ~mask;
    @(negedge clk) dack_n = 4'hF;
  endtask

  task automatic send(input logic [15:0] o, input logic [31:0] exp, input string req);
    @(negedge clk);
    ofs_valid = 1'b1; ofs_data = o; addr_ready = 1'b1;
    @(negedge clk);
    ofs_valid = 1'b0;
    check(addr_valid == 1'b1, req, 32'(addr_valid), 32'd1);
    check(addr_data == exp, req, addr_data, exp);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    check(addr_valid == 1'b0, "R1 valid", 32'(addr_valid), 0);
    check(cpu_halt == 1'b0 && hold_ack == 1'b0, "R1 hold", 32'({cpu_halt, hold_ack}), 0);
    check(ofs_ready == 1'b1, "R1 ready", 32'(ofs_ready), 1);
    for (int a = 0; a < 16; a++) rd_chk(4'(a), 8'h00, "R1 window");
    send(16'h1111, 32'h0000_1111, "R1 channel zero page zero");

    // R2 R3 R4 R8: vector table
    for (int i = 0; i < 4; i++) begin
      logic [1:0]  ch;
      logic [15:0] pg, of;
      logic [31:0] ex;
      {ch, pg, of, ex} = VEC[i];
      wr(1'b1, slot_of(ch), pg[15:8]);
      wr(1'b0, slot_of(ch), pg[7:0]);
      rd_chk(slot_of(ch), pg[7:0], "R2 slot readback");
      pulse(4'b0001 << ch);
      send(of, ex, "R8 vector address");
    end

    // R3: low write keeps high byte
    wr(1'b0, 4'd7, 8'h00);
    pulse(4'b0001);
    send(16'h0000, 32'h1200_0000, "R3 low keeps high");
    // R4: high write keeps low byte
    wr(1'b1, 4'd7, 8'h56);
    send(16'h0001, 32'h5600_0001, "R4 high keeps low");
    // R4: high write at scratch slot ignored
    wr(1'b0, 4'd4, 8'h44);
    wr(1'b1, 4'd4, 8'h99);
    rd_chk(4'd4, 8'h44, "R4 scratch untouched");
    send(16'h0000, 32'h5600_0000, "R4 pages untouched");

    // R6: bank 1 stored, never used
    wr(1'b0, 4'd15, 8'hEE);
    wr(1'b1, 4'd15, 8'h77);
    rd_chk(4'd15, 8'hEE, "R6 bank1 readback");
    rd_chk(4'd7, 8'h00, "R6 bank0 separate");
    send(16'h0002, 32'h5600_0002, "R6 bank1 ignored");

    // R5: scratch bytes distinct
    wr(1'b0, 4'd0, 8'h5A);
    rd_chk(4'd0, 8'h5A, "R5 scratch write");
    rd_chk(4'd8, 8'h00, "R5 scratch distinct");

    // R7: simultaneous falls, lowest wins
    @(negedge clk) dack_n = 4'b0101;
    @(negedge clk) dack_n = 4'b1101;
    send(16'h0000, 32'h7FFF_0000, "R7 lowest wins");
    // R7: line held low, another falls
    @(negedge clk) dack_n = 4'b1001;
    @(negedge clk) dack_n = 4'hF;
    send(16'h0005, 32'h0001_0005, "R7 new fall latches");
    send(16'h0006, 32'h0001_0006, "R7 rise does not latch");

    // R9: back-pressure
    @(negedge clk);
    addr_ready = 1'b0; ofs_valid = 1'b1; ofs_data = 16'h0010;
    @(negedge clk);
    ofs_data = 16'h0020;
    check(ofs_ready == 1'b0, "R9 ready low when full", 32'(ofs_ready), 0);
    @(negedge clk);
    check(addr_valid && addr_data == 32'h0001_0010, "R9 stall stable", addr_data, 32'h0001_0010);
    addr_ready = 1'b1;
    #1 check(ofs_ready == 1'b1, "R9 ready with drain", 32'(ofs_ready), 1);
    @(negedge clk);
    ofs_valid = 1'b0;
    check(addr_valid && addr_data == 32'h0001_0020, "R9 next beat", addr_data, 32'h0001_0020);
    @(negedge clk);
    check(addr_valid == 1'b0, "R9 drained", 32'(addr_valid), 0);

    // R10: hold handshake
    @(negedge clk) hold_req = 1'b1;
    #1 check(cpu_halt == 1'b0, "R10 not yet", 32'(cpu_halt), 0);
    @(negedge clk);
    check(cpu_halt && hold_ack, "R10 asserted", 32'({cpu_halt, hold_ack}), 32'h3);
    hold_req = 1'b0;
    @(negedge clk);
    check(!cpu_halt && !hold_ack, "R10 released", 32'({cpu_halt, hold_ack}), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule